// File: doc/BRIEF.md
# Triggered ADC Sample Sequencer

This block runs a serial successive-approximation converter that has a convert-start pin and a clocked data output. It raises the convert-start line at a fixed sample rate. It keeps the line high for a programmed number of system clock cycles, chosen to exceed the converter's worst-case conversion time of 1.5 us. When the line falls, the block clocks one 16-bit result out of the converter over a serial clock and data-in pair.

Each result leaves on a sample port with a one-cycle valid strobe and a pixel index. The index wraps after the last sample of a frame, and a one-cycle frame-done strobe marks that wrap. The pulse width, the sample period and the serial clock half period are all counted in system clock cycles. Elaboration rejects any set of values in which one read does not fit inside one sample period. The defaults give a 125 kHz sample rate from a 200 MHz clock, a 1.55 us pulse and 3692 samples per frame.

Top module: `adc_seq_top`

## Requirements
- R1: The convert-start output `adc_cnv` rises on the first clock edge after reset is released, and again every `SAMPLE_PERIOD` cycles after that.
- R2: Each convert-start pulse stays high for exactly `CONV_CYCLES` cycles.
- R3: The serial clock `adc_sclk` is low whenever `adc_cnv` is high, and it idles low between reads.
- R4: Each read begins one cycle after `adc_cnv` falls. It consists of exactly 16 serial clock periods, each `SCLK_HALF` cycles low followed by `SCLK_HALF` cycles high.
- R5: The data bits are sampled on each rising serial clock edge, most significant bit first. The first bit sampled becomes bit 15 of `smp_data`.
- R6: `smp_valid` is high for exactly one cycle per read. It is asserted `32*SCLK_HALF + 2` cycles after the clock edge that lowers `adc_cnv`, and no read that is cut short by reset produces a strobe.
- R7: `smp_index` is 0 for the first sample after reset and rises by one with each sample. It returns to 0 after the value `FRAME_LEN-1`.
- R8: `frame_done` is high for one cycle, together with `smp_valid`, only for the sample whose index is `FRAME_LEN-1`.
- R9: A synchronous active-high `rst` forces all outputs low and restarts the pulse timing and the pixel index from 0, even in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert-start pulse |
| adc_sclk | output | 1 | Serial read clock |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 16 | Converted sample value |
| smp_index | output | clog2(FRAME_LEN) | Pixel index of the sample |
| frame_done | output | 1 | One-cycle strobe with the last sample of a frame |

## Verification
Every output is a fixed function of the number of clock edges since reset was released. `adc_cnv` tracks the position `m` within the sample period. `adc_sclk` follows the offset `m-(CONV_CYCLES+1)` in half-period units. `smp_valid` falls on `m = CONV_CYCLES + 2 + 32*SCLK_HALF`. The bench recomputes that position on every falling clock edge and compares all three outputs in every cycle, so an early or late edge is seen in the cycle where it occurs. The converter model changes its data only on falling system clock edges, after a serial clock fall. Each word is compared in the exact cycle its strobe is due, against the value the model sent for that period.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMPLE_BITS = 16;

    typedef logic [SAMPLE_BITS-1:0] sample_word_t;

    // Phase of the serial read engine
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2
    } rd_phase_e;

    // Result handed from the read engine to the frame packer
    typedef struct packed {
        logic         valid;
        sample_word_t word;
    } rd_result_t;

    // Bits needed to hold values 0 .. n-1 (at least one bit)
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_cnv_timer.sv
module adc_cnv_timer
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 1600,
    parameter int CONV_CYCLES   = 310
) (
    input  logic clk,
    input  logic rst,
    output logic cnv,
    output logic rd_start
);
    localparam int PER_W = cnt_width(SAMPLE_PERIOD);
    localparam logic [PER_W-1:0] LAST_POS = PER_W'(SAMPLE_PERIOD - 1);
    localparam logic [PER_W-1:0] CONV_END = PER_W'(CONV_CYCLES);

    logic [PER_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            cnv      <= 1'b0;
            rd_start <= 1'b0;
        end else begin
            pos_q    <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            cnv      <= (pos_q < CONV_END);
            // Same edge that lowers the convert pulse
            rd_start <= (pos_q == CONV_END);
        end
    end

    // R1: a new pulse only begins once the previous period has fully elapsed
    p_cnv_rise_pos_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |-> (pos_q == PER_W'(1)));

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_seq_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_start,
    input  logic       sdo,
    output logic       sclk,
    output rd_result_t result
);
    localparam int HC_W  = cnt_width(SCLK_HALF);
    localparam int BIT_W = cnt_width(SAMPLE_BITS);
    localparam logic [HC_W-1:0]  HALF_LAST = HC_W'(SCLK_HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(SAMPLE_BITS - 1);

    rd_phase_e        phase_q;
    logic [HC_W-1:0]  half_q;
    logic [BIT_W-1:0] bit_q;
    sample_word_t     shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RD_IDLE;
            half_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            result  <= '0;
        end else begin
            result.valid <= 1'b0;
            unique case (phase_q)
                RD_IDLE: begin
                    if (rd_start) begin
                        phase_q <= RD_LOW;
                        half_q  <= '0;
                        bit_q   <= '0;
                    end
                end
                RD_LOW: begin
                    if (half_q == HALF_LAST) begin
                        half_q  <= '0;
                        phase_q <= RD_HIGH;
                        // Sample on the rising serial clock edge, MSB first
                        shift_q <= {shift_q[SAMPLE_BITS-2:0], sdo};
                    end else begin
                        half_q <= half_q + 1'b1;
                    end
                end
                RD_HIGH: begin
                    if (half_q == HALF_LAST) begin
                        half_q <= '0;
                        if (bit_q == BIT_LAST) begin
                            phase_q      <= RD_IDLE;
                            result.valid <= 1'b1;
                            result.word  <= shift_q;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            phase_q <= RD_LOW;
                        end
                    end else begin
                        half_q <= half_q + 1'b1;
                    end
                end
                default: phase_q <= RD_IDLE;
            endcase
        end
    end

    assign sclk = (phase_q == RD_HIGH);

    // R4: a read request never arrives while a read is still running
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> (phase_q == RD_IDLE));

    // R4: a finished read leaves the engine idle with the clock low
    p_done_goes_idle_r4: assert property (@(posedge clk) disable iff (rst)
        result.valid |-> (phase_q == RD_IDLE) && !sclk);

endmodule

// File: rtl/adc_frame_packer.sv
module adc_frame_packer
    import adc_seq_pkg::*;
#(
    parameter int FRAME_LEN = 3692,
    parameter int IDX_W     = cnt_width(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  rd_result_t       result,
    output logic             smp_valid,
    output sample_word_t     smp_data,
    output logic [IDX_W-1:0] smp_index,
    output logic             frame_done
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0] next_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx_q <= '0;
            smp_valid  <= 1'b0;
            smp_data   <= '0;
            smp_index  <= '0;
            frame_done <= 1'b0;
        end else begin
            smp_valid  <= result.valid;
            frame_done <= result.valid && (next_idx_q == IDX_LAST);
            if (result.valid) begin
                smp_data   <= result.word;
                smp_index  <= next_idx_q;
                next_idx_q <= (next_idx_q == IDX_LAST) ? '0 : next_idx_q + 1'b1;
            end
        end
    end

    // R8: frame end coincides with the strobe of the last pixel
    p_done_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> smp_valid && (smp_index == IDX_LAST));

    // R7: after the last pixel the next index to issue is zero
    p_index_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_index == IDX_LAST) |-> (next_idx_q == '0));

    // R6: the sample strobe lasts a single cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 1600,
    parameter int CONV_CYCLES   = 310,
    parameter int SCLK_HALF     = 4,
    parameter int FRAME_LEN     = 3692
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                adc_sdo,
    output logic                                adc_cnv,
    output logic                                adc_sclk,
    output logic                                smp_valid,
    output logic [SAMPLE_BITS-1:0]              smp_data,
    output logic [cnt_width(FRAME_LEN)-1:0]     smp_index,
    output logic                                frame_done
);
    localparam int IDX_W     = cnt_width(FRAME_LEN);
    localparam int READ_SPAN = 2 * SAMPLE_BITS * SCLK_HALF;
    localparam int HI_W      = cnt_width(CONV_CYCLES + 1);

    // Elaboration checks: one read must fit inside one sample period
    if (CONV_CYCLES < 1 || SCLK_HALF < 1 || FRAME_LEN < 2) begin : g_bad_basic
        $error("adc_seq_top: pulse width, half period and frame length must be positive");
    end
    if (CONV_CYCLES + 2 + READ_SPAN >= SAMPLE_PERIOD) begin : g_bad_fit
        $error("adc_seq_top: pulse plus serial read does not fit in the sample period");
    end

    logic       rd_start;
    rd_result_t rd_res;

    adc_cnv_timer #(
        .SAMPLE_PERIOD(SAMPLE_PERIOD),
        .CONV_CYCLES  (CONV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cnv     (adc_cnv),
        .rd_start(rd_start)
    );

    adc_serial_reader #(
        .SCLK_HALF(SCLK_HALF)
    ) u_reader (
        .clk     (clk),
        .rst     (rst),
        .rd_start(rd_start),
        .sdo     (adc_sdo),
        .sclk    (adc_sclk),
        .result  (rd_res)
    );

    adc_frame_packer #(
        .FRAME_LEN(FRAME_LEN),
        .IDX_W    (IDX_W)
    ) u_packer (
        .clk       (clk),
        .rst       (rst),
        .result    (rd_res),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_index (smp_index),
        .frame_done(frame_done)
    );

    // Checker support: length of the current convert pulse
    logic [HI_W-1:0] cnv_hi_len;
    always_ff @(posedge clk) begin
        if (rst)          cnv_hi_len <= '0;
        else if (adc_cnv) cnv_hi_len <= cnv_hi_len + 1'b1;
        else              cnv_hi_len <= '0;
    end

    // R2: pulse width equals the programmed conversion window
    p_cnv_width_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cnv) |-> (cnv_hi_len == HI_W'(CONV_CYCLES)));

    // R3: no serial clock while the converter is being started
    p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> !adc_sclk);

    // R4: the read request follows the falling edge of the pulse
    p_read_after_fall_r4: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> !adc_cnv && $past(adc_cnv));

endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
    localparam int P    = 96;
    localparam int CONV = 10;
    localparam int H    = 2;
    localparam int N    = 5;
    localparam int BITS = 16;
    localparam int VALID_POS = CONV + 2 + 2 * BITS * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adc_sdo = 1'b0;
    logic adc_cnv, adc_sclk, smp_valid, frame_done;
    logic [15:0] smp_data;
    logic [2:0]  smp_index;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_top #(
        .SAMPLE_PERIOD(P),
        .CONV_CYCLES  (CONV),
        .SCLK_HALF    (H),
        .FRAME_LEN    (N)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .adc_sdo   (adc_sdo),
        .adc_cnv   (adc_cnv),
        .adc_sclk  (adc_sclk),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_index (smp_index),
        .frame_done(frame_done)
    );

    // Converter model state
    logic [15:0] words [64];
    int conv_n, samp_n, bit_idx, rises;
    logic prev_cnv, prev_sclk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_sclk(input int n);
        int m, d;
        m = (n - 1) % P;
        d = m - (CONV + 1);
        return (d >= 0) && (d < 2 * BITS * H) && (((d / H) % 2) == 1);
    endfunction

    function automatic logic [15:0] pick_word(input int k);
        case (k)
            0: return 16'hFFFF;
            1: return 16'h0000;
            2: return 16'h8001;
            3: return 16'h7FFE;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic check_idle(input string req);
        chk(adc_cnv == 1'b0,    req, "cnv in reset",   int'(adc_cnv), 0);
        chk(adc_sclk == 1'b0,   req, "sclk in reset",  int'(adc_sclk), 0);
        chk(smp_valid == 1'b0,  req, "valid in reset", int'(smp_valid), 0);
        chk(frame_done == 1'b0, req, "done in reset",  int'(frame_done), 0);
        chk(smp_index == 3'd0,  req, "index in reset", int'(smp_index), 0);
    endtask

    task automatic run_phase(input int ncyc);
        conv_n = 0; samp_n = 0; bit_idx = 15; rises = 0;
        prev_cnv = 1'b0; prev_sclk = 1'b0;
        for (int n = 1; n <= ncyc; n++) begin
            int m;
            @(negedge clk);
            m = (n - 1) % P;
            // Converter model: new word on pulse start, next bit after each sclk fall
            if (adc_cnv && !prev_cnv) begin
                words[conv_n % 64] = pick_word(conv_n);
                conv_n++;
                bit_idx = 15;
                rises = 0;
            end
            if (adc_sclk && !prev_sclk) rises++;
            if (!adc_sclk && prev_sclk && bit_idx > 0) bit_idx--;
            if (conv_n > 0) adc_sdo = words[(conv_n - 1) % 64][bit_idx];

            // R1 / R2: convert pulse timing
            chk(adc_cnv == (m < CONV), (m == 0) ? "R1" : "R2", "cnv level",
                int'(adc_cnv), int'(m < CONV));
            // R3: quiet serial clock during the pulse
            if (adc_cnv) chk(adc_sclk == 1'b0, "R3", "sclk during cnv", int'(adc_sclk), 0);
            // R4: serial clock shape
            chk(adc_sclk == exp_sclk(n), "R4", "sclk level", int'(adc_sclk), int'(exp_sclk(n)));
            // R6: strobe timing
            chk(smp_valid == (m == VALID_POS), "R6", "valid timing",
                int'(smp_valid), int'(m == VALID_POS));
            if (smp_valid) begin
                chk(rises == BITS, "R4", "sclk pulses per read", rises, BITS);
                chk(smp_data == words[(conv_n - 1) % 64], "R5", "sample data",
                    int'(smp_data), int'(words[(conv_n - 1) % 64]));
                chk(int'(smp_index) == samp_n % N, "R7", "pixel index",
                    int'(smp_index), samp_n % N);
                chk(frame_done == ((samp_n % N) == N - 1), "R8", "frame done with sample",
                    int'(frame_done), int'((samp_n % N) == N - 1));
                samp_n++;
            end else begin
                chk(frame_done == 1'b0, "R8", "frame done without sample", int'(frame_done), 0);
            end
            prev_cnv  = adc_cnv;
            prev_sclk = adc_sclk;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        // Four full frames, then stop in the middle of a read
        run_phase(4 * N * P + 40);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R9");
        @(negedge clk);
        check_idle("R9");
        rst = 1'b0;
        // Index and timing must restart from zero
        run_phase(2 * N * P + P);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule